// File: doc/BRIEF.md
# Timer Compare Output Channel

This block is one compare channel of a 16-bit timer. Software loads a compare value and a small control word. The control word holds a three-bit action mode, a forced-output bit, a capture-select bit, an interrupt enable and a flag field. The shared timer count arrives with a count-enable strobe. A separate strobe marks the cycle in which the count reaches the period threshold kept by channel 0.

On every enabled count that equals the compare value, the channel raises its flag and applies the action chosen by the mode to its waveform output. Some modes also apply a second action on the period strobe. In mode 0 the output simply takes the software-written forced-output bit.

The waveform level is held by a two-state machine, `ST_LOW` and `ST_HIGH`, driven by an action code:
- `ACT_NONE` stays in the current state.
- `ACT_SET` moves to `ST_HIGH`.
- `ACT_CLR` moves to `ST_LOW`.
- `ACT_FLIP` swaps the state.
- `ACT_LOAD` moves to the state given by the forced-output bit.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the waveform output, flag and interrupt request are 0, the mode is 0 with forced bit 0, and the compare value is 0.
- R2: A compare event occurs on a clock edge where `tick_i` is 1, `count_i` equals the stored compare value and capture select is 0. A count that is held while `tick_i` is 0 produces no further event.
- R3: Single-action modes act on the channel's own compare event and ignore the period strobe: mode 1 sets the output, mode 4 toggles it and mode 5 clears it.
- R4: The two-action modes act on the own event first and on `period_i` (counted only with `tick_i`) second: 2 = toggle then clear, 3 = set then clear, 6 = toggle then set, 7 = clear then set. When both occur on one edge, the period action is applied.
- R5: In mode 0 the output takes the forced-output bit one edge after that bit is in the control register. Compare events in mode 0 leave the output alone but still set the flag.
- R6: Every compare event sets the flag whatever the enable. A control write with flag field 0 clears it, a write with flag field 1 leaves it unchanged, and an event on the same edge as a clearing write leaves the flag set.
- R7: `irq_o` is 1 exactly when the flag and the interrupt enable are both 1.
- R8: While capture select is 1 no event occurs: the flag is not set and the output holds.
- R9: In modes 1 to 7 the output holds its level on edges without an action.
- R10: A compare value written on an edge is used from the next edge onward. A match against the newly written value on the writing edge itself produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer count enable; count is valid for comparison |
| count_i | input | 16 | Shared timer count |
| period_i | input | 1 | Count reached the period threshold (channel 0) |
| cmp_we_i | input | 1 | Write strobe for the compare value |
| cmp_wdata_i | input | 16 | New compare value |
| ctl_we_i | input | 1 | Write strobe for the control word |
| ctl_mode_i | input | 3 | Output action mode, 0 to 7 |
| ctl_out_i | input | 1 | Forced-output bit used in mode 0 |
| ctl_cap_i | input | 1 | Capture select; 1 disables compare |
| ctl_ie_i | input | 1 | Interrupt enable |
| ctl_flag_i | input | 1 | Flag field; 0 clears the flag, 1 leaves it |
| wave_o | output | 1 | Waveform output |
| flag_o | output | 1 | Compare event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Each of the eight modes is driven through its own sequence of own-match and period-strobe cycles, starting from a known output level. This separates set, clear and toggle, and shows whether the second action is tied to the period strobe rather than to the own match. Held counts without the enable, an off-by-one count and a compare value written on the matching edge distinguish a correct match condition from one that fires too often or uses the new value too early. Clear-versus-event collisions, capture select and mode 0 forcing expose errors in flag priority and output gating.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int CNT_W  = 16;
    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SET,
        ACT_CLR,
        ACT_FLIP,
        ACT_LOAD
    } act_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_FOLLOW   = 3'd0,
        MODE_SET      = 3'd1,
        MODE_FLIP_CLR = 3'd2,
        MODE_SET_CLR  = 3'd3,
        MODE_FLIP     = 3'd4,
        MODE_CLR      = 3'd5,
        MODE_FLIP_SET = 3'd6,
        MODE_CLR_SET  = 3'd7
    } mode_e;

    // action applied on the channel's own compare event
    function automatic act_e own_action(input mode_e m);
        act_e a;
        unique case (m)
            MODE_FOLLOW:   a = ACT_NONE;
            MODE_SET:      a = ACT_SET;
            MODE_FLIP_CLR: a = ACT_FLIP;
            MODE_SET_CLR:  a = ACT_SET;
            MODE_FLIP:     a = ACT_FLIP;
            MODE_CLR:      a = ACT_CLR;
            MODE_FLIP_SET: a = ACT_FLIP;
            MODE_CLR_SET:  a = ACT_CLR;
            default:       a = ACT_NONE;
        endcase
        return a;
    endfunction

    // action applied on the period-threshold strobe
    function automatic act_e period_action(input mode_e m);
        act_e a;
        unique case (m)
            MODE_FLIP_CLR,
            MODE_SET_CLR:  a = ACT_CLR;
            MODE_FLIP_SET,
            MODE_CLR_SET:  a = ACT_SET;
            default:       a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
    parameter int CNT_W = 16
) (
    input  logic             tick_i,
    input  logic             cap_i,
    input  logic             period_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             own_hit_o,
    output logic             prd_hit_o
);
    logic live;

    always_comb begin
        live      = tick_i && !cap_i;
        own_hit_o = live && (count_i == cmp_i);
        prd_hit_o = live && period_i;
    end

endmodule

// File: rtl/ocmp_action.sv
module ocmp_action
    import ocmp_pkg::*;
(
    input  mode_e mode_i,
    input  logic  cap_i,
    input  logic  out_bit_i,
    input  logic  own_hit_i,
    input  logic  prd_hit_i,
    output act_e  act_o,
    output logic  load_o
);
    always_comb begin
        load_o = out_bit_i;
        act_o  = ACT_NONE;
        if (cap_i) begin
            act_o = ACT_NONE;
        end else if (mode_i == MODE_FOLLOW) begin
            act_o = ACT_LOAD;
        end else if (prd_hit_i && period_action(mode_i) != ACT_NONE) begin
            act_o = period_action(mode_i);
        end else if (own_hit_i) begin
            act_o = own_action(mode_i);
        end
    end

endmodule

// File: rtl/ocmp_wave_fsm.sv
module ocmp_wave_fsm
    import ocmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_e act_i,
    input  logic load_i,
    output logic wave_o
);
    typedef enum logic {ST_LOW, ST_HIGH} wst_e;

    wst_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (act_i)
            ACT_NONE: state_d = state_q;
            ACT_SET:  state_d = ST_HIGH;
            ACT_CLR:  state_d = ST_LOW;
            ACT_FLIP: state_d = (state_q == ST_HIGH) ? ST_LOW : ST_HIGH;
            ACT_LOAD: state_d = load_i ? ST_HIGH : ST_LOW;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        wave_o = (state_q == ST_HIGH);
    end

    // R3 toggle action inverts the output level
    p_flip_inverts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == ACT_FLIP |=> wave_o != $past(wave_o));

    // R5 forced bit reaches the output one edge later
    p_load_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == ACT_LOAD |=> wave_o == $past(load_i));

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [CW-1:0] count_i,
    input  logic          period_i,
    input  logic          cmp_we_i,
    input  logic [CW-1:0] cmp_wdata_i,
    input  logic          ctl_we_i,
    input  logic [2:0]    ctl_mode_i,
    input  logic          ctl_out_i,
    input  logic          ctl_cap_i,
    input  logic          ctl_ie_i,
    input  logic          ctl_flag_i,
    output logic          wave_o,
    output logic          flag_o,
    output logic          irq_o
);
    logic [CW-1:0] cmp_q;
    mode_e         mode_q;
    logic          out_q, cap_q, ie_q, flag_q;
    logic          own_hit, prd_hit, load;
    act_e          act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= MODE_FOLLOW;
            out_q  <= 1'b0;
            cap_q  <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (cmp_we_i) cmp_q <= cmp_wdata_i;
            if (ctl_we_i) begin
                mode_q <= mode_e'(ctl_mode_i);
                out_q  <= ctl_out_i;
                cap_q  <= ctl_cap_i;
                ie_q   <= ctl_ie_i;
            end
        end
    end

    // event wins over a clearing write on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (own_hit)                flag_q <= 1'b1;
        else if (ctl_we_i && !ctl_flag_i) flag_q <= 1'b0;
    end

    ocmp_match #(.CNT_W(CW)) u_match (
        .tick_i    (tick_i),
        .cap_i     (cap_q),
        .period_i  (period_i),
        .count_i   (count_i),
        .cmp_i     (cmp_q),
        .own_hit_o (own_hit),
        .prd_hit_o (prd_hit)
    );

    ocmp_action u_action (
        .mode_i    (mode_q),
        .cap_i     (cap_q),
        .out_bit_i (out_q),
        .own_hit_i (own_hit),
        .prd_hit_i (prd_hit),
        .act_o     (act),
        .load_o    (load)
    );

    ocmp_wave_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .load_i (load),
        .wave_o (wave_o)
    );

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ie_q;

    // R6 a matching enabled count always sets the flag
    p_event_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cap_q && count_i == cmp_q) |=> flag_o);

    // R8 capture select keeps a clear flag clear
    p_capture_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q && !flag_q) |=> !flag_o);

    // R9 without a count enable the output holds outside mode 0
    p_hold_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && mode_q != MODE_FOLLOW) |=> $stable(wave_o));

    // R7 request never without the flag
    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> flag_o);

endmodule

// File: tb/sim_ocmp_channel.sv
module sim_ocmp_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [15:0] count_i = '0;
    logic        period_i = 1'b0;
    logic        cmp_we_i = 1'b0;
    logic [15:0] cmp_wdata_i = '0;
    logic        ctl_we_i = 1'b0;
    logic [2:0]  ctl_mode_i = '0;
    logic        ctl_out_i = 1'b0;
    logic        ctl_cap_i = 1'b0;
    logic        ctl_ie_i = 1'b0;
    logic        ctl_flag_i = 1'b0;
    logic        wave_o, flag_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocmp_channel u0 (.*);

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // one edge of enabled count; all drives happen after a falling edge
    task automatic cnt(input logic [15:0] c, input logic prd);
        tick_i = 1'b1; count_i = c; period_i = prd;
        @(negedge clk);
        tick_i = 1'b0; period_i = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wctl(input logic [2:0] m, input logic o, input logic cap,
                        input logic ie, input logic fl);
        ctl_we_i = 1'b1; ctl_mode_i = m; ctl_out_i = o;
        ctl_cap_i = cap; ctl_ie_i = ie; ctl_flag_i = fl;
        @(negedge clk);
        ctl_we_i = 1'b0;
    endtask

    task automatic wcmp(input logic [15:0] v);
        cmp_we_i = 1'b1; cmp_wdata_i = v;
        @(negedge clk);
        cmp_we_i = 1'b0;
    endtask

    // force a known level through mode 0, flag cleared
    task automatic force_level(input logic v);
        wctl(3'd0, v, 1'b0, 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_reset();
        chk("R1", "wave", wave_o, 1'b0);
        chk("R1", "flag", flag_o, 1'b0);
        chk("R1", "irq", irq_o, 1'b0);
        cnt(16'd0, 1'b0); // reset compare value is 0, mode 0: flag set, wave stays 0
        chk("R1", "flag at count 0", flag_o, 1'b1);
        chk("R1", "wave mode0", wave_o, 1'b0);
    endtask

    task automatic t_set_mode();
        wcmp(16'd100);
        force_level(1'b0);
        wctl(3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        cnt(16'd99, 1'b0);
        chk("R2", "no event off by one", flag_o, 1'b0);
        chk("R2", "wave off by one", wave_o, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R3", "mode1 set", wave_o, 1'b1);
        chk("R6", "flag without enable", flag_o, 1'b1);
        chk("R7", "irq disabled", irq_o, 1'b0);
        wctl(3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6", "write 1 keeps flag", flag_o, 1'b1);
        wctl(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6", "write 0 clears", flag_o, 1'b0);
        count_i = 16'd100; idle(); idle();
        chk("R2", "held count no event", flag_o, 1'b0);
        chk("R9", "held level", wave_o, 1'b1);
    endtask

    task automatic t_single();
        force_level(1'b1);
        wctl(3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R3", "mode4 toggle down", wave_o, 1'b0);
        cnt(16'd5, 1'b1);
        chk("R3", "mode4 ignores period", wave_o, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R3", "mode4 toggle up", wave_o, 1'b1);
        wctl(3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R3", "mode5 clear", wave_o, 1'b0);
        wctl(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt(16'd5, 1'b1);
        chk("R3", "mode1 ignores period", wave_o, 1'b0);
    endtask

    task automatic t_dual();
        force_level(1'b0);
        wctl(3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R4", "mode3 own sets", wave_o, 1'b1);
        idle();
        chk("R9", "mode3 holds", wave_o, 1'b1);
        cnt(16'd7, 1'b1);
        chk("R4", "mode3 period clears", wave_o, 1'b0);
        force_level(1'b1);
        wctl(3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R4", "mode7 own clears", wave_o, 1'b0);
        cnt(16'd100, 1'b1);
        chk("R4", "mode7 both: period set wins", wave_o, 1'b1);
        period_i = 1'b1; idle(); period_i = 1'b0;
        chk("R4", "period without tick ignored", wave_o, 1'b1);
        force_level(1'b1);
        wctl(3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R4", "mode2 own toggle", wave_o, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R4", "mode2 own toggle again", wave_o, 1'b1);
        cnt(16'd3, 1'b1);
        chk("R4", "mode2 period clears", wave_o, 1'b0);
        force_level(1'b0);
        wctl(3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R4", "mode6 own toggle", wave_o, 1'b1);
        cnt(16'd100, 1'b0);
        chk("R4", "mode6 own toggle again", wave_o, 1'b0);
        cnt(16'd3, 1'b1);
        chk("R4", "mode6 period sets", wave_o, 1'b1);
    endtask

    task automatic t_follow();
        force_level(1'b0);
        wctl(3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5", "not yet forced", wave_o, 1'b0);
        idle();
        chk("R5", "forced high", wave_o, 1'b1);
        cnt(16'd100, 1'b0);
        chk("R5", "event keeps forced level", wave_o, 1'b1);
        chk("R5", "event sets flag in mode0", flag_o, 1'b1);
        wctl(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R5", "forced low", wave_o, 1'b0);
    endtask

    task automatic t_irq();
        force_level(1'b0);
        wctl(3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7", "enable without flag", irq_o, 1'b0);
        cnt(16'd100, 1'b0);
        chk("R7", "irq raised", irq_o, 1'b1);
        wctl(3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7", "enable dropped", irq_o, 1'b0);
        chk("R7", "flag kept", flag_o, 1'b1);
        // clear and event on one edge
        ctl_we_i = 1'b1; ctl_mode_i = 3'd1; ctl_ie_i = 1'b1; ctl_flag_i = 1'b0;
        ctl_cap_i = 1'b0; ctl_out_i = 1'b0;
        cnt(16'd100, 1'b0);
        ctl_we_i = 1'b0;
        chk("R6", "event beats clear", flag_o, 1'b1);
        wctl(3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7", "cleared flag drops irq", irq_o, 1'b0);
    endtask

    task automatic t_capture();
        force_level(1'b0);
        wctl(3'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        cnt(16'd100, 1'b1);
        chk("R8", "no flag in capture", flag_o, 1'b0);
        chk("R8", "wave held in capture", wave_o, 1'b0);
        chk("R8", "no irq in capture", irq_o, 1'b0);
    endtask

    task automatic t_cmp_write();
        force_level(1'b0);
        wctl(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        cmp_we_i = 1'b1; cmp_wdata_i = 16'd200;
        cnt(16'd200, 1'b0);
        cmp_we_i = 1'b0;
        chk("R10", "new value not used on write edge", flag_o, 1'b0);
        cnt(16'd200, 1'b0);
        chk("R10", "new value used next", flag_o, 1'b1);
        chk("R10", "wave set by new value", wave_o, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_set_mode();
        t_single();
        t_dual();
        t_follow();
        t_irq();
        t_capture();
        t_cmp_write();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule